// File: doc/BRIEF.md
# Pseudo-Random Memory Self-Test Engine

This block is a built-in self-test controller that sits in front of a synchronous 32-bit word memory with four byte write strobes. A one-cycle start pulse launches a fixed test program. The program first runs several word rounds. Each round fills a sparse, evenly spaced set of word locations with values from a reseeded 32-bit xorshift generator. It then rebuilds the same value sequence from the same seed and compares it with the data read back. After the word rounds, a byte pass writes the lowest bytes of the memory one lane at a time and reads them back.

The engine stops at the first mismatch. It reports done and pass, the byte address of the failure, and a flag that tells a byte-phase failure from a word-phase failure. The memory depth, the spacing of the word walk, the number of rounds and the length of the byte pass are all parameters. The memory array itself is outside the block. It is expected to return read data on the clock after the address is presented.

Top module: `mem_bist`

## Requirements
- R1: The pattern source is a 32-bit xorshift that applies three steps in this order: x ^= x<<13, x ^= x>>17, x ^= x<<5. The updated x is the value used. Each written or expected word is the next such value.
- R2: There are ROUNDS word rounds (default 5), numbered 1 upward. Round i loads the seed i before its write pass and loads it again before its verify pass.
- R3: A word round touches only word indices 0, STRIDE, 2·STRIDE and so on, below MEM_WORDS. It writes them all in ascending order, with mem_wstrb = 4'b1111, and then verifies them in the same order. No other word is written by the word phase.
- R4: In the verify pass, the first read word that differs from its regenerated value ends the whole test. The result is done=1, pass=0, fail_addr = 4 × word index and fail_in_bytes=0.
- R5: After all word rounds pass, the byte phase writes byte offsets 0 to BYTE_SPAN-1 (default 128) in ascending order. The value written is the offset. mem_addr is the offset divided by 4. Exactly one strobe bit is set: bit number offset[1:0]. The byte is copied onto all four data lanes.
- R6: The byte phase then reads the offsets back in ascending order, taking lane offset[1:0] of the read word. The first mismatch gives done=1, pass=0, fail_addr = offset and fail_in_bytes=1. If every byte matches, the result is done=1 and pass=1.
- R7: Every read is followed by one cycle with no access, and the compare uses the data returned in that cycle. So a word write costs 1 cycle, a word check 2 cycles, a byte write 1 cycle and a byte check 2 cycles.
- R8: round_ok is high for exactly one cycle after each word round whose verify pass succeeds.
- R9: A start pulse in idle or after completion clears done on the next edge and begins the test. A start pulse while busy has no effect. done, pass, fail_addr and fail_in_bytes hold their values until the next accepted start.
- R10: During and after reset the engine is idle. mem_en=0, mem_wstrb=0, busy=0, done=0 and round_ok=0.
- R11: With N = ceil(MEM_WORDS/STRIDE), a clean run raises done on edge 3·N·ROUNDS + 3·BYTE_SPAN + 1, counting the edge that accepts start as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to run the test |
| mem_en | output | 1 | Memory access this cycle (a read when mem_wstrb is zero) |
| mem_addr | output | $clog2(MEM_WORDS) | Word address |
| mem_wstrb | output | 4 | Byte write strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished, held until next start |
| pass | output | 1 | Finished with no mismatch |
| round_ok | output | 1 | One-cycle pulse per passing word round |
| fail_addr | output | $clog2(MEM_WORDS)+2 | Byte address of the first mismatch |
| fail_in_bytes | output | 1 | 1: failure in byte phase, 0: word phase |

## Verification
Every result has a fixed arrival time measured from the edge that accepts start. A word mismatch at index k in the first round ends the test on edge N+3+2k. A byte mismatch at offset b ends it on edge 3·N·ROUNDS+2b+131. A clean run ends on the edge given in R11. The bench counts edges one at a time, samples the outputs at the falling edge after each count, and requires done to be low before the predicted edge and high on it. round_ok pulses are counted over the same window, and memory contents are compared with a model computed in the bench once the engine is idle.

// File: rtl/mem_bist_pkg.sv
package mem_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD_WR,
        ST_WORD_RD,
        ST_WORD_CMP,
        ST_BYTE_WR,
        ST_BYTE_RD,
        ST_BYTE_CMP,
        ST_FIN
    } bist_state_e;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

endpackage

// File: rtl/bist_xorshift.sv
module bist_xorshift
    import mem_bist_pkg::*;
(
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] nxt
);
    localparam int NSTEP = 3;
    localparam int SH [NSTEP] = '{13, 17, 5};
    localparam bit LEFT [NSTEP] = '{1'b1, 1'b0, 1'b1};

    logic [DATA_W-1:0] stage [NSTEP+1];

    assign stage[0] = cur;

    // each step folds a shifted copy of the running value back into it
    for (genvar s = 0; s < NSTEP; s++) begin : g_step
        if (LEFT[s]) begin : g_left
            assign stage[s+1] = stage[s] ^ (stage[s] << SH[s]);
        end else begin : g_right
            assign stage[s+1] = stage[s] ^ (stage[s] >> SH[s]);
        end
    end

    assign nxt = stage[NSTEP];
endmodule

// File: rtl/bist_lane.sv
module bist_lane
    import mem_bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_wr,
    input  logic              byte_wr,
    input  logic [1:0]        lane_sel,
    input  logic [DATA_W-1:0] word_data,
    input  logic [7:0]        byte_val,
    input  logic [DATA_W-1:0] rdata,
    output logic [LANES-1:0]  wstrb,
    output logic [DATA_W-1:0] wdata,
    output logic [7:0]        rbyte
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign wstrb[l] = word_wr | (byte_wr && (lane_sel == 2'(l)));
        assign wdata[8*l +: 8] = word_wr ? word_data[8*l +: 8] : byte_val;
    end

    always_comb begin
        rbyte = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_sel == 2'(l)) rbyte = rdata[8*l +: 8];
        end
    end

    // R5: a byte write drives exactly one strobe, and on that lane the byte value
    p_byte_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |-> ($countones(wstrb) == 1) && (wdata[7:0] == byte_val)
                    && (wdata[31:24] == byte_val));
endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import mem_bist_pkg::*;
#(
    parameter int MEM_WORDS = 32768,
    parameter int STRIDE    = 256,
    parameter int ROUNDS    = 5,
    parameter int BYTE_SPAN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rng_next,
    input  logic [DATA_W-1:0] rdata,
    input  logic [7:0]        rbyte,
    output logic [DATA_W-1:0] rng_cur,
    output logic              acc_en,
    output logic [$clog2(MEM_WORDS)-1:0] acc_addr,
    output logic              word_wr,
    output logic              byte_wr,
    output logic [1:0]        lane_sel,
    output logic [7:0]        byte_val,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              round_ok,
    output logic [$clog2(MEM_WORDS)+1:0] fail_addr,
    output logic              fail_in_bytes
);
    localparam int AW    = $clog2(MEM_WORDS);
    localparam int FA_W  = AW + 2;
    localparam int IDX_W = $clog2(MEM_WORDS + STRIDE) + 1;
    localparam int BI_W  = $clog2(BYTE_SPAN) + 1;
    localparam int RC_W  = $clog2(ROUNDS + 1) + 1;

    typedef struct packed {
        bist_state_e       st;
        logic [RC_W-1:0]   rnd;
        logic [IDX_W-1:0]  idx;
        logic [BI_W-1:0]   boff;
        logic [DATA_W-1:0] rng;
        logic              done;
        logic              pass;
        logic              round_ok;
        logic              fail_ph;
        logic [FA_W-1:0]   fail_addr;
    } ctrl_t;

    ctrl_t q, d;

    logic word_last, byte_last;
    assign word_last = (q.idx + IDX_W'(STRIDE)) >= IDX_W'(MEM_WORDS);
    assign byte_last = (q.boff == BI_W'(BYTE_SPAN - 1));

    always_comb begin
        d = q;
        d.round_ok = 1'b0;
        unique case (q.st)
            ST_IDLE, ST_FIN: begin
                if (start) begin
                    d.st        = ST_WORD_WR;
                    d.rnd       = RC_W'(1);
                    d.idx       = '0;
                    d.boff      = '0;
                    d.rng       = DATA_W'(1);
                    d.done      = 1'b0;
                    d.pass      = 1'b0;
                    d.fail_ph   = 1'b0;
                    d.fail_addr = '0;
                end
            end
            ST_WORD_WR: begin
                d.rng = rng_next;
                if (word_last) begin
                    d.idx = '0;
                    d.rng = DATA_W'(q.rnd);
                    d.st  = ST_WORD_RD;
                end else begin
                    d.idx = q.idx + IDX_W'(STRIDE);
                end
            end
            ST_WORD_RD: d.st = ST_WORD_CMP;
            ST_WORD_CMP: begin
                if (rdata != rng_next) begin
                    d.st        = ST_FIN;
                    d.done      = 1'b1;
                    d.pass      = 1'b0;
                    d.fail_ph   = 1'b0;
                    d.fail_addr = {q.idx[AW-1:0], 2'b00};
                end else if (word_last) begin
                    d.idx      = '0;
                    d.round_ok = 1'b1;
                    if (q.rnd == RC_W'(ROUNDS)) begin
                        d.st   = ST_BYTE_WR;
                        d.boff = '0;
                    end else begin
                        d.rnd = q.rnd + RC_W'(1);
                        d.rng = DATA_W'(q.rnd + RC_W'(1));
                        d.st  = ST_WORD_WR;
                    end
                end else begin
                    d.rng = rng_next;
                    d.idx = q.idx + IDX_W'(STRIDE);
                    d.st  = ST_WORD_RD;
                end
            end
            ST_BYTE_WR: begin
                if (byte_last) begin
                    d.boff = '0;
                    d.st   = ST_BYTE_RD;
                end else begin
                    d.boff = q.boff + BI_W'(1);
                end
            end
            ST_BYTE_RD: d.st = ST_BYTE_CMP;
            ST_BYTE_CMP: begin
                if (rbyte != 8'(q.boff)) begin
                    d.st        = ST_FIN;
                    d.done      = 1'b1;
                    d.pass      = 1'b0;
                    d.fail_ph   = 1'b1;
                    d.fail_addr = FA_W'(q.boff);
                end else if (byte_last) begin
                    d.st   = ST_FIN;
                    d.done = 1'b1;
                    d.pass = 1'b1;
                end else begin
                    d.boff = q.boff + BI_W'(1);
                    d.st   = ST_BYTE_RD;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, rnd: '0, idx: '0, boff: '0, rng: '0,
                   done: 1'b0, pass: 1'b0, round_ok: 1'b0, fail_ph: 1'b0,
                   fail_addr: '0};
        end else begin
            q <= d;
        end
    end

    logic byte_st;
    assign byte_st  = (q.st == ST_BYTE_WR) || (q.st == ST_BYTE_RD);
    assign acc_en   = (q.st == ST_WORD_WR) || (q.st == ST_WORD_RD) || byte_st;
    assign acc_addr = byte_st ? AW'(q.boff >> 2) : q.idx[AW-1:0];
    assign word_wr  = (q.st == ST_WORD_WR);
    assign byte_wr  = (q.st == ST_BYTE_WR);
    assign lane_sel = q.boff[1:0];
    assign byte_val = 8'(q.boff);
    assign rng_cur  = q.rng;

    assign busy          = (q.st != ST_IDLE) && (q.st != ST_FIN);
    assign done          = q.done;
    assign pass          = q.pass;
    assign round_ok      = q.round_ok;
    assign fail_addr     = q.fail_addr;
    assign fail_in_bytes = q.fail_ph;

    // R8: the round pulse never lasts two cycles
    p_round_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        round_ok |=> !round_ok);

    // R9: results stay frozen until a new start arrives
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done && $stable(pass) && $stable(fail_addr)
                             && $stable(fail_in_bytes));

    // R4: a word-phase failure always names a word-aligned byte address
    p_word_fail_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pass && !fail_in_bytes) |-> (fail_addr[1:0] == 2'b00));

    // R9: start while busy leaves the engine busy
    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(q.st == ST_BYTE_CMP)
         && !(q.st == ST_WORD_CMP)) |=> busy);
endmodule

// File: rtl/mem_bist.sv
module mem_bist
    import mem_bist_pkg::*;
#(
    parameter int MEM_WORDS = 32768,
    parameter int STRIDE    = 256,
    parameter int ROUNDS    = 5,
    parameter int BYTE_SPAN = 128
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         mem_en,
    output logic [$clog2(MEM_WORDS)-1:0] mem_addr,
    output logic [3:0]                   mem_wstrb,
    output logic [31:0]                  mem_wdata,
    input  logic [31:0]                  mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic                         pass,
    output logic                         round_ok,
    output logic [$clog2(MEM_WORDS)+1:0] fail_addr,
    output logic                         fail_in_bytes
);
    logic [DATA_W-1:0] rng_cur, rng_next;
    logic              word_wr, byte_wr;
    logic [1:0]        lane_sel;
    logic [7:0]        byte_val, rbyte;

    bist_xorshift i_prng (
        .cur (rng_cur),
        .nxt (rng_next)
    );

    bist_ctrl #(
        .MEM_WORDS (MEM_WORDS),
        .STRIDE    (STRIDE),
        .ROUNDS    (ROUNDS),
        .BYTE_SPAN (BYTE_SPAN)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .rng_next      (rng_next),
        .rdata         (mem_rdata),
        .rbyte         (rbyte),
        .rng_cur       (rng_cur),
        .acc_en        (mem_en),
        .acc_addr      (mem_addr),
        .word_wr       (word_wr),
        .byte_wr       (byte_wr),
        .lane_sel      (lane_sel),
        .byte_val      (byte_val),
        .busy          (busy),
        .done          (done),
        .pass          (pass),
        .round_ok      (round_ok),
        .fail_addr     (fail_addr),
        .fail_in_bytes (fail_in_bytes)
    );

    bist_lane i_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_wr   (word_wr),
        .byte_wr   (byte_wr),
        .lane_sel  (lane_sel),
        .word_data (rng_next),
        .byte_val  (byte_val),
        .rdata     (mem_rdata),
        .wstrb     (mem_wstrb),
        .wdata     (mem_wdata),
        .rbyte     (rbyte)
    );

    // R10: an idle engine issues no access and no strobe
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_en && (mem_wstrb == 4'b0000)));

    // R7: every read is followed by a cycle with no access
    p_read_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && (mem_wstrb == 4'b0000)) |=> !mem_en);

    // R3: a write is only ever issued together with mem_en
    p_strobe_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wstrb != 4'b0000) |-> mem_en);
endmodule

// File: tb/test_mem_bist.sv
`timescale 1ns/1ps
module test_mem_bist;
    localparam int MW   = 256;
    localparam int STR  = 16;
    localparam int RNDS = 5;
    localparam int BSP  = 128;
    localparam int N    = (MW + STR - 1) / STR;
    localparam int CLEAN_EDGE = 3 * N * RNDS + 3 * BSP + 1;
    localparam int BYTE_BASE  = 3 * N * RNDS + BSP + 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mem_en;
    logic [7:0]  mem_addr;
    logic [3:0]  mem_wstrb;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        busy, done, pass, round_ok, fail_in_bytes;
    logic [9:0]  fail_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mem_bist #(.MEM_WORDS(MW), .STRIDE(STR), .ROUNDS(RNDS), .BYTE_SPAN(BSP)) i_mem_bist (
        .clk (clk), .rst_n (rst_n), .start (start),
        .mem_en (mem_en), .mem_addr (mem_addr), .mem_wstrb (mem_wstrb),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
        .busy (busy), .done (done), .pass (pass), .round_ok (round_ok),
        .fail_addr (fail_addr), .fail_in_bytes (fail_in_bytes)
    );

    // memory model with one-cycle read latency and a read-side fault injector
    logic [31:0] mem [MW];
    logic [31:0] rd_q;
    logic [7:0]  rd_addr_q;
    int          fault_word = -1;
    logic [31:0] fault_mask = '0;

    always_ff @(posedge clk) begin
        if (mem_en) begin
            for (int l = 0; l < 4; l++)
                if (mem_wstrb[l]) mem[mem_addr][8*l +: 8] <= mem_wdata[8*l +: 8];
            rd_q      <= mem[mem_addr];
            rd_addr_q <= mem_addr;
        end
    end
    assign mem_rdata = rd_q ^ ((int'(rd_addr_q) == fault_word) ? fault_mask : 32'h0);

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x = v;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic preload();
        for (int i = 0; i < MW; i++) mem[i] = 32'hC3000000 | i;
    endtask

    task automatic run(input int exp_edge, input bit exp_pass, input int exp_addr,
                       input bit exp_ph, input int exp_rok, input int inj_edge,
                       input string req);
        int e;
        int rok;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        e = 1;
        rok = round_ok ? 1 : 0;
        chk(busy && !done, "R9", "start clears done", {busy, done}, 2'b10);
        while (!done && e < 5000) begin
            start = (e == inj_edge);
            @(posedge clk);
            @(negedge clk);
            e++;
            if (round_ok) rok++;
        end
        start = 1'b0;
        chk(e == exp_edge, req, "done edge", e, exp_edge);
        chk(pass == exp_pass, req, "pass", pass, exp_pass);
        if (!exp_pass) begin
            chk(int'(fail_addr) == exp_addr, req, "fail_addr", fail_addr, exp_addr);
            chk(fail_in_bytes == exp_ph, req, "phase", fail_in_bytes, exp_ph);
        end
        chk(rok == exp_rok, "R8", "round_ok pulses", rok, exp_rok);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] x;
        logic [9:0]  hold_addr;
        preload();
        start = 1'b1;
        repeat (4) @(negedge clk);
        // R10: reset state, start during reset ignored
        chk(!mem_en && mem_wstrb == 0, "R10", "no access in reset", {mem_en, mem_wstrb}, 0);
        chk(!busy && !done && !round_ok, "R10", "idle flags", {busy, done, round_ok}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_en, "R10", "idle after reset", {busy, mem_en}, 0);

        // R11 R6: clean run; a start injected mid-run must change nothing (R9)
        run(CLEAN_EDGE, 1'b1, 0, 1'b0, RNDS, 100, "R11");
        // R1 R2 R3: strided words hold round-5 sequence beyond the byte area
        x = 32'd5;
        for (int k = 0; k < N; k++) begin
            x = xs(x);
            if (k * STR >= BSP / 4)
                chk(mem[k*STR] == x, "R1", "round-5 word", mem[k*STR], x);
        end
        // R5: byte area holds offset pattern
        for (int w = 0; w < BSP / 4; w++)
            chk(mem[w] == {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)}, "R5",
                "byte pattern", mem[w], {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        chk(mem[33] == (32'hC3000000 | 33), "R3", "unstrided word untouched",
            mem[33], 32'hC3000000 | 33);

        // R9: hold after completion
        hold_addr = fail_addr;
        repeat (20) @(negedge clk);
        chk(done && pass && fail_addr == hold_addr, "R9", "result hold",
            {done, pass}, 2'b11);

        // R4 R7: word fault at index 2 of round 1
        preload();
        fault_word = 2 * STR; fault_mask = 32'h0000_0100;
        run(N + 3 + 2*2, 1'b0, 4 * 2 * STR, 1'b0, 0, -1, "R4");
        x = xs(32'd1);
        chk(mem[0] == x, "R1", "round-1 first word", mem[0], x);
        x = xs(x);
        chk(mem[STR] == x, "R2", "round-1 second word", mem[STR], x);

        // R4: fault at word 0 lane 0, first compare
        preload();
        fault_word = 0; fault_mask = 32'h0000_00FF;
        run(N + 3, 1'b0, 0, 1'b0, 0, -1, "R4");

        // R3: fault on an unstrided word outside the byte area is never seen
        preload();
        fault_word = 40; fault_mask = 32'hFFFF_FFFF;
        run(CLEAN_EDGE, 1'b1, 0, 1'b0, RNDS, -1, "R3");

        // R6: byte fault on word 5 lane 2 -> byte offset 22
        preload();
        fault_word = 5; fault_mask = 32'h0010_0000;
        run(BYTE_BASE + 2*22, 1'b0, 22, 1'b1, RNDS, -1, "R6");

        // R6: byte fault at the last byte offset (word 31 lane 3)
        preload();
        fault_word = 31; fault_mask = 32'h8000_0000;
        run(BYTE_BASE + 2*(BSP-1), 1'b0, BSP - 1, 1'b1, RNDS, -1, "R6");

        fault_word = -1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule